// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by walking a two-level translation table that lives in ordinary memory. On a start pulse it captures the linear address and the base address of the top-level directory, reads one directory entry through a request/response memory port, and uses that entry to find the second-level table. It then reads one entry of that table, which supplies the 20-bit frame number. The frame number, joined to the untouched 12-bit page offset, forms the physical address.

The walk ends with a one-cycle completion pulse or a one-cycle fault pulse. A fault reports which level lacked a present translation. The frame number and physical address stay on the outputs until the next accepted start, so a translation cache can take them as a fill at any later time. The memory port issues one single-cycle request per level and then waits any number of cycles for the response. The reset input is asynchronous and active low, and its deassertion must already be aligned to the clock.

Top module: `pgwalk_top`

## Requirements
- R1: The linear address splits into a directory index (bits 31:22), a table index (bits 21:12) and a page offset (bits 11:0). The first memory request goes to the captured directory base plus four times the directory index.
- R2: Bits 31:12 of a present directory entry, with twelve zero bits appended, form the base of the second-level table. The second request goes to that base plus four times the table index.
- R3: When the table entry is present, frame_o takes entry bits 31:12 and phys_addr_o takes the frame followed by the original offset. done_o is high for exactly one cycle, in the same cycle those values appear. For example, 00003FA2h translates to 16317FA2h and 00801116h translates to 3F000116h.
- R4: Bit 0 of every entry is the present flag, and the other low bits of an entry are ignored. A directory entry with bit 0 clear ends the walk with a one-cycle fault_o pulse and fault_level_o = 0. No second memory request is made.
- R5: A second-level entry with bit 0 clear ends the walk with a one-cycle fault_o pulse and fault_level_o = 1. done_o stays low and exactly two requests are made.
- R6: mem_req_o is a single-cycle pulse, and mem_addr_o is valid with it. The walker waits for mem_rvalid_i for as many cycles as needed, at least one cycle after the request. A mem_rvalid_i that arrives while no response is awaited has no effect.
- R7: busy_o is high from the cycle after an accepted start until the cycle after the done or fault pulse. A start while busy_o is high is ignored. The linear address and directory base are captured only when a start is accepted.
- R8: Accepting a start clears frame_o, phys_addr_o and fault_level_o to zero. After that, the result outputs change only when a walk completes and then hold until the next accepted start.
- R9: After reset, busy_o, done_o, fault_o and mem_req_o are low and the result outputs are zero.
- R10: done_o and fault_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a walk (taken only when idle) |
| lin_addr_i | input | 32 | Linear address to translate |
| dir_base_i | input | 32 | Byte address of the page directory |
| mem_req_o | output | 1 | Single-cycle memory read request |
| mem_addr_o | output | 32 | Byte address of the entry being read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Entry returned by memory |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse: translation succeeded |
| fault_o | output | 1 | One-cycle pulse: entry not present |
| fault_level_o | output | 1 | Level of the last fault (0 directory, 1 table) |
| frame_o | output | 20 | Translated frame number |
| phys_addr_o | output | 32 | Translated physical address |

## Verification
The hardest situations to reach from the ports are a start pulse, with a different linear address, arriving halfway through a walk, and a stray response while the walker is idle. Either one, if mishandled, would quietly redirect the second read or corrupt a held result. The bench includes a memory model that derives every entry arithmetically from its address. It sweeps every directory index and every table index, with response latencies of two to four cycles. On a fixed fraction of walks it injects a mid-walk start with the complemented address, and on others a stray response just before the start. Non-present entries fall at regular index positions, so both fault levels and the stated example translations come up in the same sweep.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_RD_DIR = 3'd1,
    S_WT_DIR = 3'd2,
    S_RD_TBL = 3'd3,
    S_WT_TBL = 3'd4,
    S_DONE   = 3'd5,
    S_FAULT  = 3'd6
  } walk_state_t;

  localparam int unsigned LVL_DIR = 0;
  localparam int unsigned LVL_TBL = 1;

endpackage

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
  import pgwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        rvalid_i,
  input  logic        present_i,
  output walk_state_t state_o,
  output logic        accept_o,
  output logic        dir_rsp_o,
  output logic        tbl_rsp_o
);

  walk_state_t state_q;
  walk_state_t state_d;

  assign accept_o  = (state_q == S_IDLE)   && start_i;
  assign dir_rsp_o = (state_q == S_WT_DIR) && rvalid_i;
  assign tbl_rsp_o = (state_q == S_WT_TBL) && rvalid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (start_i)  state_d = S_RD_DIR;
      S_RD_DIR:               state_d = S_WT_DIR;
      S_WT_DIR: if (rvalid_i) state_d = present_i ? S_RD_TBL : S_FAULT;
      S_RD_TBL:               state_d = S_WT_TBL;
      S_WT_TBL: if (rvalid_i) state_d = present_i ? S_DONE : S_FAULT;
      S_DONE:                 state_d = S_IDLE;
      S_FAULT:                state_d = S_IDLE;
      default:                state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/pgwalk_addr_gen.sv
module pgwalk_addr_gen #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DIR_IDX_W   = 10,
  parameter int unsigned TBL_IDX_W   = 10,
  parameter int unsigned ENTRY_SHIFT = 2,
  localparam int unsigned OFF_W      = ADDR_W - DIR_IDX_W - TBL_IDX_W,
  localparam int unsigned FRAME_W    = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept_i,
  input  logic               dir_take_i,
  input  logic               sel_tbl_i,
  input  logic [ADDR_W-1:0]  lin_addr_i,
  input  logic [ADDR_W-1:0]  dir_base_i,
  input  logic [FRAME_W-1:0] entry_hi_i,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [OFF_W-1:0]   offset_o
);

  logic [ADDR_W-1:0]  lin_q;
  logic [ADDR_W-1:0]  dbase_q;
  logic [FRAME_W-1:0] tbase_q;

  logic [DIR_IDX_W-1:0] dir_idx;
  logic [TBL_IDX_W-1:0] tbl_idx;
  logic [ADDR_W-1:0]    dir_ent_addr;
  logic [ADDR_W-1:0]    tbl_ent_addr;

  assign dir_idx  = lin_q[ADDR_W-1 -: DIR_IDX_W];
  assign tbl_idx  = lin_q[OFF_W +: TBL_IDX_W];
  assign offset_o = lin_q[OFF_W-1:0];

  assign dir_ent_addr = dbase_q + (ADDR_W'(dir_idx) << ENTRY_SHIFT);
  assign tbl_ent_addr = {tbase_q, {OFF_W{1'b0}}} + (ADDR_W'(tbl_idx) << ENTRY_SHIFT);
  assign mem_addr_o   = sel_tbl_i ? tbl_ent_addr : dir_ent_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_q   <= '0;
      dbase_q <= '0;
    end else if (accept_i) begin
      lin_q   <= lin_addr_i;
      dbase_q <= dir_base_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tbase_q <= '0;
    else if (dir_take_i) tbase_q <= entry_hi_i;
  end

endmodule

// File: rtl/pgwalk_result.sv
module pgwalk_result #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned OFF_W   = 12,
  localparam int unsigned FRAME_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept_i,
  input  logic               tbl_hit_i,
  input  logic               dir_miss_i,
  input  logic               tbl_miss_i,
  input  logic [FRAME_W-1:0] entry_hi_i,
  input  logic [OFF_W-1:0]   offset_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [ADDR_W-1:0]  phys_o,
  output logic               fault_lvl_o
);

  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [ADDR_W-1:0]  phys_q, phys_d;
  logic               lvl_q, lvl_d;
  logic               res_en;

  assign res_en = accept_i || tbl_hit_i || dir_miss_i || tbl_miss_i;

  always_comb begin
    frame_d = frame_q;
    phys_d  = phys_q;
    lvl_d   = lvl_q;
    if (accept_i) begin
      frame_d = '0;
      phys_d  = '0;
      lvl_d   = 1'b0;
    end else if (tbl_hit_i) begin
      frame_d = entry_hi_i;
      phys_d  = {entry_hi_i, offset_i};
    end else if (dir_miss_i) begin
      lvl_d   = 1'(pgwalk_pkg::LVL_DIR);
    end else if (tbl_miss_i) begin
      lvl_d   = 1'(pgwalk_pkg::LVL_TBL);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      phys_q  <= '0;
      lvl_q   <= 1'b0;
    end else if (res_en) begin
      frame_q <= frame_d;
      phys_q  <= phys_d;
      lvl_q   <= lvl_d;
    end
  end

  assign frame_o     = frame_q;
  assign phys_o      = phys_q;
  assign fault_lvl_o = lvl_q;

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DIR_IDX_W   = 10,
  parameter int unsigned TBL_IDX_W   = 10,
  parameter int unsigned ENTRY_SHIFT = 2,
  parameter int unsigned PRESENT_POS = 0,
  localparam int unsigned OFF_W      = ADDR_W - DIR_IDX_W - TBL_IDX_W,
  localparam int unsigned FRAME_W    = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  lin_addr_i,
  input  logic [ADDR_W-1:0]  dir_base_i,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [ADDR_W-1:0]  mem_rdata_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               fault_o,
  output logic               fault_level_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [ADDR_W-1:0]  phys_addr_o
);

  walk_state_t        state;
  logic               accept, dir_rsp, tbl_rsp, present;
  logic [FRAME_W-1:0] entry_hi;
  logic [OFF_W-1:0]   offset;
  logic               unused_entry_bits;

  assign present           = mem_rdata_i[PRESENT_POS];
  assign entry_hi          = mem_rdata_i[ADDR_W-1:OFF_W];
  assign unused_entry_bits = ^mem_rdata_i[OFF_W-1:0];

  pgwalk_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rvalid_i  (mem_rvalid_i),
    .present_i (present),
    .state_o   (state),
    .accept_o  (accept),
    .dir_rsp_o (dir_rsp),
    .tbl_rsp_o (tbl_rsp)
  );

  pgwalk_addr_gen #(
    .ADDR_W      (ADDR_W),
    .DIR_IDX_W   (DIR_IDX_W),
    .TBL_IDX_W   (TBL_IDX_W),
    .ENTRY_SHIFT (ENTRY_SHIFT)
  ) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (accept),
    .dir_take_i (dir_rsp && present),
    .sel_tbl_i  (state == S_RD_TBL),
    .lin_addr_i (lin_addr_i),
    .dir_base_i (dir_base_i),
    .entry_hi_i (entry_hi),
    .mem_addr_o (mem_addr_o),
    .offset_o   (offset)
  );

  pgwalk_result #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
  ) u_res (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .tbl_hit_i   (tbl_rsp && present),
    .dir_miss_i  (dir_rsp && !present),
    .tbl_miss_i  (tbl_rsp && !present),
    .entry_hi_i  (entry_hi),
    .offset_i    (offset),
    .frame_o     (frame_o),
    .phys_o      (phys_addr_o),
    .fault_lvl_o (fault_level_o)
  );

  assign mem_req_o = (state == S_RD_DIR) || (state == S_RD_TBL);
  assign busy_o    = (state != S_IDLE);
  assign done_o    = (state == S_DONE);
  assign fault_o   = (state == S_FAULT);

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              mem_req_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              fault_o,
  input logic [ADDR_W-1:0] phys_addr_o
);

  p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o);

  p_idle_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_fault_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> !fault_o && !busy_o);

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fault_o));

  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o && mem_req_o);

  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phys_addr_o) |-> (done_o || $past(start_i && !busy_o)));

endmodule

bind pgwalk_top pgwalk_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .mem_req_o   (mem_req_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .phys_addr_o (phys_addr_o)
);

// File: tb/pgwalk_top_bench.sv
module pgwalk_top_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] lin_addr_i;
  logic [31:0] dir_base_i;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i;
  logic [31:0] mem_rdata_i;
  logic        busy_o, done_o, fault_o, fault_level_o;
  logic [19:0] frame_o;
  logic [31:0] phys_addr_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] cur_db;

  pgwalk_top u_pgwalk_top (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .lin_addr_i(lin_addr_i),
    .dir_base_i(dir_base_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i), .busy_o(busy_o),
    .done_o(done_o), .fault_o(fault_o), .fault_level_o(fault_level_o),
    .frame_o(frame_o), .phys_addr_o(phys_addr_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // Memory model: present flag in bit 0, other low bits are filler to be ignored (R4).
  function automatic logic [19:0] dir_tbase(input int i);
    if (i == 0) return 20'h01000;
    if (i == 2) return 20'h02000;
    return 20'(32'h100 + i);
  endfunction
  function automatic bit dir_present(input int i);
    return (i % 5) != 4;
  endfunction
  function automatic logic [19:0] tbl_frame(input logic [19:0] t, input int j);
    if (t == 20'h01000 && j == 3) return 20'h16317;
    if (t == 20'h02000 && j == 1) return 20'h3F000;
    return 20'((32'(t) * 13 + j) & 32'hFFFFF);
  endfunction
  function automatic bit tbl_present(input int j);
    return (j % 6) != 5;
  endfunction
  function automatic logic [31:0] mem_model(input logic [31:0] a);
    if (a >= cur_db && a < cur_db + 32'h1000) begin
      int i = int'((a - cur_db) >> 2);
      return {dir_tbase(i), 11'h5A4, dir_present(i)};
    end else begin
      logic [19:0] t = a[31:12];
      int j = int'(a[11:2]);
      return {tbl_frame(t, j), 11'h2C2, tbl_present(j)};
    end
  endfunction

  task automatic walk(input logic [31:0] la, input int lat, input bit glitch, input bit stray);
    int nreq = 0, pend = 0, cyc = 0;
    bit fin = 0, got_done = 0, got_fault = 0, got_lvl = 0;
    logic [31:0] ad[2];
    logic [31:0] raddr = '0, ph = '0;
    logic [19:0] fr = '0;
    int i = int'(la[31:22]);
    int j = int'(la[21:12]);
    logic [19:0] tb = dir_tbase(i);
    bit exp_df = !dir_present(i);
    bit exp_tf = !exp_df && !tbl_present(j);
    logic [19:0] ef = tbl_frame(tb, j);
    ad[0] = '0; ad[1] = '0;
    @(negedge clk);
    if (stray) begin
      mem_rvalid_i = 1'b1; mem_rdata_i = 32'hFFFF_F000; // stray, not awaited (R6)
      @(negedge clk);
      mem_rvalid_i = 1'b0;
    end
    start_i = 1'b1; lin_addr_i = la; dir_base_i = cur_db;
    @(negedge clk);
    start_i = 1'b0;
    while (!fin && cyc < 64) begin
      mem_rvalid_i = 1'b0;
      start_i = 1'b0;
      if (glitch && cyc == 1) begin
        start_i = 1'b1; lin_addr_i = ~la; dir_base_i = cur_db ^ 32'h0F00_0000; // R7
      end
      if (done_o || fault_o) begin
        fin = 1; got_done = done_o; got_fault = fault_o; got_lvl = fault_level_o;
        fr = frame_o; ph = phys_addr_o;
      end else begin
        if (mem_req_o) begin
          if (nreq < 2) ad[nreq] = mem_addr_o;
          nreq++; raddr = mem_addr_o; pend = lat;
        end
        if (pend > 0) begin
          pend--;
          if (pend == 0) begin mem_rvalid_i = 1'b1; mem_rdata_i = mem_model(raddr); end
        end
        @(negedge clk);
        cyc++;
      end
    end
    start_i = 1'b0; mem_rvalid_i = 1'b0;
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL R6: walk for %h never ended (actual none, expected done/fault)", la);
      return;
    end
    check("R1 dir entry address", ad[0], cur_db + 32'(i) * 4);
    if (exp_df) begin
      check("R4 dir fault", {29'd0, got_fault, got_done, got_lvl}, 32'b100);
      check("R4 single request", 32'(nreq), 32'd1);
      check("R8 cleared result", ph, 32'h0);
    end else if (exp_tf) begin
      check("R2 table entry address", ad[1], {tb, 12'h0} + 32'(j) * 4);
      check("R5 table fault", {29'd0, got_fault, got_done, got_lvl}, 32'b101);
      check("R5 two requests", 32'(nreq), 32'd2);
      check("R8 cleared frame", {12'd0, fr}, 32'h0);
    end else begin
      check("R2 table entry address", ad[1], {tb, 12'h0} + 32'(j) * 4);
      check("R3 done pulse", {30'd0, got_done, got_fault}, 32'b10);
      check("R3 frame", {12'd0, fr}, {12'd0, ef});
      check("R3 physical address", ph, {ef, la[11:0]});
      check("R6 request count", 32'(nreq), 32'd2);
    end
    @(negedge clk);
    check("R3 pulse one cycle", {29'd0, done_o, fault_o, busy_o}, 32'b000);
    @(negedge clk);
    check("R8 result held", phys_addr_o, ph);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; lin_addr_i = '0; dir_base_i = '0;
    mem_rvalid_i = 1'b0; mem_rdata_i = '0; cur_db = 32'h0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset flags", {28'd0, busy_o, done_o, fault_o, mem_req_o}, 32'h0);
    check("R9 reset phys", phys_addr_o, 32'h0);
    check("R9 reset frame", {12'd0, frame_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 stated example translations
    walk(32'h0000_3FA2, 2, 0, 0);
    check("R3 example 1", phys_addr_o, 32'h1631_7FA2);
    walk(32'h0080_1116, 3, 1, 1);
    check("R3 example 2", phys_addr_o, 32'h3F00_0116);

    // Sweep every directory index
    for (int i = 0; i < 1024; i++) begin
      logic [9:0] jj = 10'((i * 37 + 5) % 1024);
      logic [11:0] off = 12'((i * 97) & 12'hFFF);
      walk({10'(i), jj, off}, 2 + (i % 3), (i % 7) == 0, (i % 11) == 3);
    end

    // Sweep every table index under a different directory base
    cur_db = 32'h0007_3000;
    for (int j = 0; j < 1024; j++) begin
      walk({10'd1, 10'(j), 12'(j * 13)}, 2 + (j % 3), (j % 5) == 1, (j % 9) == 2);
    end

    finish_run();
  end

endmodule